// File: doc/BRIEF.md
# Home-to-Update Address Redirection Lookup

This block sits on the read path of a persistent-memory controller and answers one question for every last-level-cache miss: where does the newest copy of this line live? Lines that were modified inside a transaction and then evicted are written to a separate update region instead of their home location. The block keeps a hashed, set-associative table that maps each such home line address to its update-region address. It also keeps a small buffer of lines that garbage collection is copying back home, so that a read issued during that copy still sees the newest data.

A lookup that hits the table returns the update-region address and drops the entry, since the line now lives in the cache hierarchy. A lookup that misses the table falls back to the eviction buffer, which returns the line's data. If both miss, the read goes to the home address. Inserts come from transactional evictions. Removes come from garbage collection once a line has been migrated home. Eviction-buffer entries are pushed by garbage collection and freed when it acknowledges that the home write has completed. When remove, insert and lookup meet in one cycle, they are applied in that order.

Top module: `redir_lookup`

## Requirements
- R1: After a synchronous active-low reset the table and the eviction buffer are empty: `rsp_valid`, `need_gc` and `evb_full` are 0, and any lookup returns the home source.
- R2: A lookup of a home address present in the table answers with `rsp_src` = 2'b01 (update region) and `rsp_addr` equal to the stored update-region address.
- R3: A lookup that hits the table removes that entry, so a following lookup of the same address with no new insert does not answer 2'b01.
- R4: A lookup that misses the table but matches an eviction-buffer entry answers `rsp_src` = 2'b10 with `rsp_data` equal to the buffered line and `rsp_addr` equal to the lookup address. The lookup does not free the buffer entry.
- R5: A lookup that misses both answers `rsp_src` = 2'b00 with `rsp_addr` equal to the lookup address and `rsp_data` of zero.
- R6: A remove request deletes the matching table entry, and a later lookup of that address no longer answers 2'b01.
- R7: An insert for a home address already in the table replaces that entry's update-region address instead of adding a second entry.
- R8: The set of an address is the XOR of all its bit positions folded modulo log2(SETS), so address bit i goes to set bit i mod log2(SETS). An insert of a new address into a set whose WAYS entries are all valid is dropped. It raises `need_gc` for exactly the following cycle, and the existing entries are kept. `need_gc` is never raised in a cycle that does not follow an insert.
- R9: Within one cycle, remove is applied first, then insert, then lookup, and the lookup sees the state those two leave behind.
- R10: An acknowledge frees the matching eviction-buffer entry. `evb_full` is 1 exactly when all DEPTH entries are valid. A push to a full buffer with a new address is ignored. A push with an address already buffered overwrites its data. Within a cycle, acknowledge precedes push, and both precede the lookup.
- R11: Every lookup request produces exactly one response, with `rsp_valid` high on the cycle after the request and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Cache-miss lookup request |
| lk_addr | input | AW | Home line address to resolve |
| ins_valid | input | 1 | Transactional eviction insert |
| ins_home | input | AW | Home line address of the inserted mapping |
| ins_upd | input | AW | Update-region address of the inserted mapping |
| rm_valid | input | 1 | Garbage-collection remove request |
| rm_home | input | AW | Home line address to unmap |
| evb_push | input | 1 | Garbage collection stages a line being written home |
| evb_addr | input | AW | Home address of the staged line |
| evb_data | input | DW | Data of the staged line |
| evb_ack | input | 1 | Home write of a staged line has completed |
| evb_ack_addr | input | AW | Home address whose write completed |
| evb_full | output | 1 | All eviction-buffer entries are in use |
| need_gc | output | 1 | Previous insert found its set full and was dropped |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_src | output | 2 | 00 home, 01 update region, 10 eviction buffer |
| rsp_addr | output | AW | Address to read from |
| rsp_data | output | DW | Line data when answered from the eviction buffer |

## Verification
The functions most likely to collide are a lookup and the table updates from insert and remove, which can name the same address in the same cycle. The buffer acknowledge and push can likewise coincide with a lookup. Directed cycles drive remove, insert and lookup of one address together, and a remove together with a lookup. A long seeded random run then draws every request type independently from a small address pool, crowded into one set, so that collisions and full sets occur often. Each answer is judged against a reference model that applies remove, insert and lookup in that order, and buffer acknowledge before push before lookup.

// File: rtl/redir_pkg.sv
// Shared types for the home-to-update redirection lookup.
// Assumes: source encoding is fixed and decoded by the read path.
package redir_pkg;
    typedef enum logic [1:0] {
        SRC_HOME = 2'b00,
        SRC_UPD  = 2'b01,
        SRC_EVB  = 2'b10
    } src_e;
endpackage

// File: rtl/redir_way_match.sv
// Parallel comparator across the ways of one table row.
// Assumes: at most one valid way holds a given key.
module redir_way_match #(
    parameter int WAYS = 4,
    parameter int AW   = 32
) (
    input  logic [WAYS-1:0]         valid,
    input  logic [WAYS-1:0][AW-1:0] keys,
    input  logic [AW-1:0]           key,
    output logic [WAYS-1:0]         hit
);
    // One comparator per way.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign hit[g] = valid[g] && (keys[g] == key);
    end
endmodule

// File: rtl/redir_map_table.sv
// Hashed set-associative home->update address map.
// Applies remove, then insert, then lookup within one cycle; a lookup hit
// clears the entry. An insert of a new key into a full set is dropped and
// flagged through ins_full.
// Assumes: SETS is a power of two, at least 2.
module redir_map_table #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    parameter int AW   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_valid,
    input  logic [AW-1:0] lk_addr,
    input  logic          ins_valid,
    input  logic [AW-1:0] ins_home,
    input  logic [AW-1:0] ins_upd,
    input  logic          rm_valid,
    input  logic [AW-1:0] rm_home,
    output logic          lk_hit,
    output logic [AW-1:0] lk_upd,
    output logic          ins_full
);
    localparam int SET_W = $clog2(SETS);

    typedef logic [WAYS-1:0][AW-1:0] row_t;

    logic [SETS-1:0][WAYS-1:0]         v_q;
    logic [SETS-1:0][WAYS-1:0][AW-1:0] h_q;
    logic [SETS-1:0][WAYS-1:0][AW-1:0] u_q;

    // XOR fold of every address bit into the set index.
    function automatic logic [SET_W-1:0] set_of(input logic [AW-1:0] a);
        logic [SET_W-1:0] r;
        r = '0;
        for (int i = 0; i < AW; i++) r[i % SET_W] ^= a[i];
        return r;
    endfunction

    logic [SET_W-1:0] rs, is_, ls;
    logic [WAYS-1:0]  rm_hit, rm_clr, iv, ins_hit, ins_free, ins_wr;
    logic [WAYS-1:0]  lv, lk_hit_v, lk_clr;
    row_t             lk_keys, lk_upds;

    assign rs  = set_of(rm_home);
    assign is_ = set_of(ins_home);
    assign ls  = set_of(lk_addr);

    // Stage 1: remove against the stored row.
    redir_way_match #(.WAYS(WAYS), .AW(AW)) u_rm (
        .valid(v_q[rs]), .keys(h_q[rs]), .key(rm_home), .hit(rm_hit)
    );
    assign rm_clr = rm_valid ? rm_hit : '0;

    // Stage 2: insert sees the row after the remove.
    assign iv = v_q[is_] & ~((rs == is_) ? rm_clr : '0);
    redir_way_match #(.WAYS(WAYS), .AW(AW)) u_ins (
        .valid(iv), .keys(h_q[is_]), .key(ins_home), .hit(ins_hit)
    );

    // Pick the lowest free way of the insert row.
    always_comb begin
        logic found;
        found    = 1'b0;
        ins_free = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!iv[w] && !found) begin
                ins_free[w] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    assign ins_wr   = !ins_valid ? '0 : ((|ins_hit) ? ins_hit : ins_free);
    assign ins_full = ins_valid && !(|ins_hit) && !(|ins_free);

    // Stage 3: lookup row after remove and insert.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_keys[w] = (is_ == ls && ins_wr[w]) ? ins_home : h_q[ls][w];
            lk_upds[w] = (is_ == ls && ins_wr[w]) ? ins_upd  : u_q[ls][w];
        end
    end
    assign lv = (v_q[ls] & ~((rs == ls) ? rm_clr : '0)) | ((is_ == ls) ? ins_wr : '0);

    redir_way_match #(.WAYS(WAYS), .AW(AW)) u_lk (
        .valid(lv), .keys(lk_keys), .key(lk_addr), .hit(lk_hit_v)
    );
    assign lk_clr = lk_valid ? lk_hit_v : '0;
    assign lk_hit = |lk_clr;

    // Select the update address of the hitting way.
    always_comb begin
        lk_upd = '0;
        for (int w = 0; w < WAYS; w++)
            if (lk_clr[w]) lk_upd |= lk_upds[w];
    end

    // Valid bits: later writes in this block take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (SET_W'(s) == rs  && rm_clr[w]) v_q[s][w] <= 1'b0;
                    if (SET_W'(s) == is_ && ins_wr[w]) v_q[s][w] <= 1'b1;
                    if (SET_W'(s) == ls  && lk_clr[w]) v_q[s][w] <= 1'b0;
                end
            end
        end
    end

    // Entry payload written on insert only.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (SET_W'(s) == is_ && ins_wr[w]) begin
                    h_q[s][w] <= ins_home;
                    u_q[s][w] <= ins_upd;
                end
            end
        end
    end
endmodule

// File: rtl/redir_evict_buf.sv
// Fully associative buffer of lines being written home by garbage collection.
// Acknowledge frees, then push fills or overwrites, then lookup reads.
// Assumes: each home address occupies at most one entry.
module redir_evict_buf #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_valid,
    input  logic [AW-1:0] ack_addr,
    input  logic          push_valid,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data,
    output logic          full
);
    logic [DEPTH-1:0]         v_q, av, pm, pf, wr;
    logic [DEPTH-1:0][AW-1:0] a_q;
    logic [DEPTH-1:0][DW-1:0] d_q;

    // Chained acknowledge, push and lookup evaluation.
    always_comb begin
        logic found;
        av = v_q;
        for (int i = 0; i < DEPTH; i++)
            if (ack_valid && v_q[i] && a_q[i] == ack_addr) av[i] = 1'b0;
        pm = '0;
        for (int i = 0; i < DEPTH; i++)
            if (av[i] && a_q[i] == push_addr) pm[i] = 1'b1;
        pf    = '0;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!av[i] && !found) begin
                pf[i] = 1'b1;
                found = 1'b1;
            end
        end
        wr = !push_valid ? '0 : ((|pm) ? pm : pf);
        lk_hit  = 1'b0;
        lk_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr[i] && push_addr == lk_addr) begin
                lk_hit  = 1'b1;
                lk_data |= push_data;
            end else if (!wr[i] && av[i] && a_q[i] == lk_addr) begin
                lk_hit  = 1'b1;
                lk_data |= d_q[i];
            end
        end
    end

    assign full = &v_q;

    // Occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= av | wr;
    end

    // Address and data capture on push.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr[i]) begin
                a_q[i] <= push_addr;
                d_q[i] <= push_data;
            end
        end
    end
endmodule

// File: rtl/redir_lookup.sv
// Read-path redirection: resolves each cache-miss lookup to the update
// region, the eviction buffer or the home address, one cycle after request.
// Assumes: requesters hold no handshake; every request is accepted.
module redir_lookup
    import redir_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_valid,
    input  logic [AW-1:0] lk_addr,
    input  logic          ins_valid,
    input  logic [AW-1:0] ins_home,
    input  logic [AW-1:0] ins_upd,
    input  logic          rm_valid,
    input  logic [AW-1:0] rm_home,
    input  logic          evb_push,
    input  logic [AW-1:0] evb_addr,
    input  logic [DW-1:0] evb_data,
    input  logic          evb_ack,
    input  logic [AW-1:0] evb_ack_addr,
    output logic          evb_full,
    output logic          need_gc,
    output logic          rsp_valid,
    output logic [1:0]    rsp_src,
    output logic [AW-1:0] rsp_addr,
    output logic [DW-1:0] rsp_data
);
    logic          t_hit, t_full, e_hit;
    logic [AW-1:0] t_upd;
    logic [DW-1:0] e_data;
    src_e          src_q;

    redir_map_table #(.SETS(SETS), .WAYS(WAYS), .AW(AW)) u_tab (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .ins_valid(ins_valid), .ins_home(ins_home), .ins_upd(ins_upd),
        .rm_valid(rm_valid), .rm_home(rm_home),
        .lk_hit(t_hit), .lk_upd(t_upd), .ins_full(t_full)
    );

    redir_evict_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_evb (
        .clk(clk), .rst_n(rst_n),
        .ack_valid(evb_ack), .ack_addr(evb_ack_addr),
        .push_valid(evb_push), .push_addr(evb_addr), .push_data(evb_data),
        .lk_addr(lk_addr),
        .lk_hit(e_hit), .lk_data(e_data), .full(evb_full)
    );

    assign rsp_src = src_q;

    // Register the resolved source, address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            need_gc   <= 1'b0;
            src_q     <= SRC_HOME;
            rsp_addr  <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            need_gc   <= t_full;
            if (lk_valid) begin
                if (t_hit) begin
                    src_q    <= SRC_UPD;
                    rsp_addr <= t_upd;
                    rsp_data <= '0;
                end else if (e_hit) begin
                    src_q    <= SRC_EVB;
                    rsp_addr <= lk_addr;
                    rsp_data <= e_data;
                end else begin
                    src_q    <= SRC_HOME;
                    rsp_addr <= lk_addr;
                    rsp_data <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/redir_lookup_checker.sv
// Port-level properties of the redirection lookup, bound to the top.
module redir_lookup_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_valid,
    input logic [AW-1:0] lk_addr,
    input logic          ins_valid,
    input logic [AW-1:0] ins_home,
    input logic          evb_push,
    input logic          evb_full,
    input logic          need_gc,
    input logic          rsp_valid,
    input logic [1:0]    rsp_src,
    input logic [AW-1:0] rsp_addr
);
    // R11: a request is answered on the next cycle.
    a_r11_answer: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R11: no answer without a request.
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R5: a home answer carries the requested address.
    a_r5_home_addr: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_src != 2'b00 || rsp_addr == $past(lk_addr)));
    // R4: only the three defined source codes appear.
    a_r4_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_src != 2'b11);
    // R8: need_gc only follows an insert.
    a_r8_gc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> !need_gc);
    // R3: a repeated lookup with no fresh insert cannot hit the table.
    a_r3_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(lk_valid) && lk_addr == $past(lk_addr)
         && !(ins_valid && ins_home == lk_addr)) |=> rsp_src != 2'b01);
    // R10: the buffer cannot become full without a push.
    a_r10_full_by_push: assert property (@(posedge clk) disable iff (!rst_n)
        !evb_push |=> !$rose(evb_full));
endmodule

bind redir_lookup redir_lookup_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .ins_valid(ins_valid), .ins_home(ins_home), .evb_push(evb_push),
    .evb_full(evb_full), .need_gc(need_gc), .rsp_valid(rsp_valid),
    .rsp_src(rsp_src), .rsp_addr(rsp_addr)
);

// File: tb/redir_lookup_test.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a priority-ordered reference model.
module redir_lookup_test;
    localparam int AW = 32, DW = 64, SETS = 16, WAYS = 4, EBD = 4;
    localparam int SW = 4;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          lk_valid = 0, ins_valid = 0, rm_valid = 0, evb_push = 0, evb_ack = 0;
    logic [AW-1:0] lk_addr = 0, ins_home = 0, ins_upd = 0, rm_home = 0, evb_addr = 0, evb_ack_addr = 0;
    logic [DW-1:0] evb_data = 0;
    logic          evb_full, need_gc, rsp_valid;
    logic [1:0]    rsp_src;
    logic [AW-1:0] rsp_addr;
    logic [DW-1:0] rsp_data;

    always #2 clk = ~clk;

    redir_lookup #(.AW(AW), .DW(DW), .SETS(SETS), .WAYS(WAYS), .DEPTH(EBD)) uut (.*);

    int checks = 0, fails = 0;

    bit            mv [SETS][WAYS];
    logic [AW-1:0] mh [SETS][WAYS];
    logic [AW-1:0] mu [SETS][WAYS];
    bit            ev [EBD];
    logic [AW-1:0] ea [EBD];
    logic [DW-1:0] ed [EBD];
    bit            e_valid, e_gc;
    logic [1:0]    e_src;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;

    function automatic int hashf(input logic [AW-1:0] a);
        logic [SW-1:0] r = '0;
        for (int i = 0; i < AW; i++) r[i % SW] ^= a[i];
        return int'(r);
    endfunction

    function automatic bit evb_model_full();
        int n = 0;
        for (int i = 0; i < EBD; i++) n += ev[i];
        return n == EBD;
    endfunction

    // Reference model: remove, insert, buffer ack, push, then lookup.
    task automatic model_step();
        int s, k;
        bit done;
        e_gc = 0;
        if (rm_valid) begin
            s = hashf(rm_home);
            for (int w = 0; w < WAYS; w++) if (mv[s][w] && mh[s][w] == rm_home) mv[s][w] = 0;
        end
        if (ins_valid) begin
            s = hashf(ins_home); k = -1;
            for (int w = 0; w < WAYS; w++) if (mv[s][w] && mh[s][w] == ins_home) k = w;
            if (k < 0) for (int w = WAYS-1; w >= 0; w--) if (!mv[s][w]) k = w;
            if (k < 0) e_gc = 1;
            else begin mv[s][k] = 1; mh[s][k] = ins_home; mu[s][k] = ins_upd; end
        end
        if (evb_ack) for (int i = 0; i < EBD; i++) if (ev[i] && ea[i] == evb_ack_addr) ev[i] = 0;
        if (evb_push) begin
            k = -1;
            for (int i = 0; i < EBD; i++) if (ev[i] && ea[i] == evb_addr) k = i;
            if (k < 0) for (int i = EBD-1; i >= 0; i--) if (!ev[i]) k = i;
            if (k >= 0) begin ev[k] = 1; ea[k] = evb_addr; ed[k] = evb_data; end
        end
        e_valid = lk_valid;
        if (lk_valid) begin
            done = 0; s = hashf(lk_addr);
            e_src = 2'b00; e_addr = lk_addr; e_data = '0;
            for (int w = 0; w < WAYS; w++)
                if (!done && mv[s][w] && mh[s][w] == lk_addr) begin
                    e_src = 2'b01; e_addr = mu[s][w]; mv[s][w] = 0; done = 1;
                end
            for (int i = 0; i < EBD; i++)
                if (!done && ev[i] && ea[i] == lk_addr) begin
                    e_src = 2'b10; e_data = ed[i]; done = 1;
                end
        end
    endtask

    task automatic chk(input string tag);
        checks++;
        if (rsp_valid !== e_valid) begin
            fails++; $display("FAIL %s R11 rsp_valid act=%b exp=%b", tag, rsp_valid, e_valid);
        end
        if (e_valid) begin
            checks++;
            if (rsp_src !== e_src || rsp_addr !== e_addr || rsp_data !== e_data) begin
                fails++;
                $display("FAIL %s src/addr/data act=%b/%h/%h exp=%b/%h/%h",
                         tag, rsp_src, rsp_addr, rsp_data, e_src, e_addr, e_data);
            end
        end
        checks++;
        if (need_gc !== e_gc) begin
            fails++; $display("FAIL %s R8 need_gc act=%b exp=%b", tag, need_gc, e_gc);
        end
        checks++;
        if (evb_full !== evb_model_full()) begin
            fails++; $display("FAIL %s R10 evb_full act=%b exp=%b", tag, evb_full, evb_model_full());
        end
    endtask

    // Apply the inputs already set, sample after the edge, then idle them.
    task automatic cyc(input string tag);
        model_step();
        @(negedge clk);
        chk(tag);
        lk_valid = 0; ins_valid = 0; rm_valid = 0; evb_push = 0; evb_ack = 0;
    endtask

    task automatic do_lk(input logic [AW-1:0] a, input string tag);
        lk_valid = 1; lk_addr = a; cyc(tag);
    endtask
    task automatic do_ins(input logic [AW-1:0] h, input logic [AW-1:0] u, input string tag);
        ins_valid = 1; ins_home = h; ins_upd = u; cyc(tag);
    endtask
    task automatic do_rm(input logic [AW-1:0] h, input string tag);
        rm_valid = 1; rm_home = h; cyc(tag);
    endtask
    task automatic do_push(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        evb_push = 1; evb_addr = a; evb_data = d; cyc(tag);
    endtask
    task automatic do_ack(input logic [AW-1:0] a, input string tag);
        evb_ack = 1; evb_ack_addr = a; cyc(tag);
    endtask

    // Same-set address: the k pattern lands in nibbles 0 and 1 and cancels.
    function automatic logic [AW-1:0] same_set(input logic [AW-1:0] base, input int k);
        return base ^ AW'((k << 4) | k);
    endfunction

    function automatic logic [AW-1:0] pool(input int i);
        if (i < 8) return same_set(32'h0040_1000, i);
        return 32'h0123_0000 + AW'(i * 37);
    endfunction

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) mv[s][w] = 0;
        for (int i = 0; i < EBD; i++) ev[i] = 0;
        e_valid = 0; e_gc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset");
        do_lk(32'h0000_5a5a, "R1 R5 empty lookup");
        // R2, R3
        do_ins(32'h0000_1100, 32'h00ab_0001, "R2 insert");
        do_lk(32'h0000_1100, "R2 hit");
        do_lk(32'h0000_1100, "R3 consumed");
        // R7
        do_ins(32'h0000_2200, 32'h00ab_0002, "R7 first");
        do_ins(32'h0000_2200, 32'h00ab_0003, "R7 overwrite");
        do_lk(32'h0000_2200, "R7 newest");
        // R6
        do_ins(32'h0000_3300, 32'h00ab_0004, "R6 insert");
        do_rm(32'h0000_3300, "R6 remove");
        do_lk(32'h0000_3300, "R6 gone");
        // R4, R10 acknowledge
        do_push(32'h0000_4400, 64'hdead_beef_0000_0001, "R4 push");
        do_lk(32'h0000_4400, "R4 buffer hit");
        do_lk(32'h0000_4400, "R4 still buffered");
        do_ack(32'h0000_4400, "R10 ack");
        do_lk(32'h0000_4400, "R10 R5 freed");
        // R8 full set
        for (int k = 0; k < WAYS; k++) do_ins(same_set(32'h0000_7700, k), 32'h00cd_0000 + AW'(k), "R8 fill");
        do_ins(same_set(32'h0000_7700, WAYS), 32'h00cd_00ff, "R8 overflow");
        do_lk(same_set(32'h0000_7700, WAYS), "R8 dropped");
        do_lk(same_set(32'h0000_7700, 0), "R8 kept");
        // R9 same-cycle priority
        do_ins(32'h0000_8800, 32'h00ef_0001, "R9 setup");
        rm_valid = 1; rm_home = 32'h0000_8800;
        ins_valid = 1; ins_home = 32'h0000_8800; ins_upd = 32'h00ef_0002;
        lk_valid = 1; lk_addr = 32'h0000_8800;
        cyc("R9 rm+ins+lk");
        do_ins(32'h0000_9900, 32'h00ef_0003, "R9 setup2");
        rm_valid = 1; rm_home = 32'h0000_9900; lk_valid = 1; lk_addr = 32'h0000_9900;
        cyc("R9 rm+lk");
        // R10 buffer capacity and overwrite
        for (int i = 0; i < EBD; i++) do_push(32'h0001_0000 + AW'(i), 64'h1000 + DW'(i), "R10 fill");
        do_push(32'h0001_00ff, 64'h9999, "R10 push when full");
        do_lk(32'h0001_00ff, "R10 ignored push");
        do_push(32'h0001_0002, 64'h7777, "R10 overwrite");
        do_lk(32'h0001_0002, "R10 overwritten data");
        for (int i = 0; i < EBD; i++) do_ack(32'h0001_0000 + AW'(i), "R10 drain");
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            rm_valid  = ($urandom_range(0, 9) < 2); rm_home  = pool($urandom_range(0, 11));
            ins_valid = ($urandom_range(0, 9) < 4); ins_home = pool($urandom_range(0, 11));
            ins_upd   = $urandom();
            lk_valid  = ($urandom_range(0, 9) < 5); lk_addr  = pool($urandom_range(0, 11));
            evb_ack   = ($urandom_range(0, 9) < 2); evb_ack_addr = pool($urandom_range(0, 11));
            evb_push  = ($urandom_range(0, 9) < 2); evb_addr = pool($urandom_range(0, 11));
            evb_data  = {$urandom(), $urandom()};
            cyc("R9 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule